// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block turns one input clock into two banks of divided clocks. Each bank drives a group of output pairs, and each pair carries a true and a complementary output. Bank A runs at half or a quarter of the input rate. Bank B runs at a quarter or a sixth of the input rate. Each bank has its own select bit. Every divided clock has a 50% duty cycle, including the divide-by-6 ratio.

An active-low enable passes through a short synchronizer before it reaches the banks. When the enable is withdrawn, each bank finishes the period it is in and then parks with its true outputs low. When the enable returns, both banks start together from the low phase, so the first pulse has full width. A change of select bit takes effect only at the end of the bank's current period, so it never produces a shortened pulse. A synchronous active-high master reset restarts both dividers and forces every true output low. An asynchronous active-low reset brings the block to the parked state.

The block is modelled as synchronous logic clocked by the input clock. Analog levels, skew and delay are not modelled.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: Bank A divides by 2 when `sel_a_i` is 0 and by 4 when it is 1.
- R2: Bank B divides by 4 when `sel_b_i` is 0 and by 6 when it is 1.
- R3: When `mreset_i` is sampled high at a clock edge, all true outputs are low and all complementary outputs are high after that edge. With the enable active, counting restarts from the low phase on the first edge at which `mreset_i` is low, so bank A at divide-by-2 goes high after that edge.
- R4: `en_ni` is active low and passes through `SYNC_STAGES` (default 2) flops. After a low level is sampled on the first edge, bank A goes high after the third edge at divide-by-2, and bank B goes high after the fourth edge at divide-by-4.
- R5: While `en_ni` is held high, each bank completes its current period and then holds all of its true outputs low.
- R6: On re-enable after a park, both banks restart from the start of their low phase at the same time. With the default synchronizer, bank A at divide-by-2 first goes high on the 3rd sample, bank B at divide-by-6 first goes high on the 5th sample, and bank B's first high pulse lasts 3 cycles.
- R7: Every divided output is high for N/2 input cycles and low for N/2 input cycles, where N is the ratio in use.
- R8: A change of select bit is applied only at the end of the bank's current period. The period in progress completes with the old ratio.
- R9: Each complementary output is always the inverse of its true output.
- R10: All pairs within a bank carry identical values on every cycle.
- R11: While `rst_ni` is low, all true outputs are low and all complementary outputs are high. After `rst_ni` is released, the outputs stay parked until the enable has passed through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreset_i | input | 1 | Synchronous master reset, active high |
| en_ni | input | 1 | Output enable, active low, asynchronous to the clock |
| sel_a_i | input | 1 | Bank A ratio: 0 selects /2, 1 selects /4 |
| sel_b_i | input | 1 | Bank B ratio: 0 selects /4, 1 selects /6 |
| qa_o | output | PAIRS | Bank A true outputs |
| qa_n_o | output | PAIRS | Bank A complementary outputs |
| qb_o | output | PAIRS | Bank B true outputs |
| qb_n_o | output | PAIRS | Bank B complementary outputs |

## Verification
Some properties are checked by assertions on every cycle:
- complement and pair-copy integrity;
- clearing by master reset;
- parking low after the enable has been withdrawn for long enough;
- a bank B pulse, high or low, never lasting a single cycle.

The exact ratios, the 50% duty, the synchronizer latency, the aligned restart and the deferral of a select change depend on phase and history. The bench's scenarios show these by measuring edges and pulse widths, and by comparing every cycle against an independent phase model under random enable, select and reset traffic.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int unsigned DEF_PAIRS = 2;
  localparam int unsigned DEF_SYNC  = 2;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/clkdiv_en_sync.sv
`timescale 1ns/1ps
module clkdiv_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic run_o
);
  logic [STAGES-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= ~en_ni;
      for (int i = 1; i < int'(STAGES); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign run_o = st_q[STAGES-1];
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank import clkdiv_pkg::*; #(
  parameter int unsigned DIV_LO = 2,
  parameter int unsigned DIV_HI = 4,
  parameter int unsigned PAIRS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             sel_i,
  output logic [PAIRS-1:0] q_o,
  output logic [PAIRS-1:0] qn_o
);
  localparam int unsigned DIV_MAX = max2(DIV_LO, DIV_HI);
  localparam int unsigned CW      = $clog2(DIV_MAX);
  localparam logic [CW-1:0] LO_LAST = CW'(DIV_LO - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(DIV_HI - 1);
  localparam logic [CW-1:0] LO_HALF = CW'(DIV_LO / 2);
  localparam logic [CW-1:0] HI_HALF = CW'(DIV_HI / 2);

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc, last, half;
  logic          sel_q, sel_d, hi_d;

  assign last    = sel_q ? HI_LAST : LO_LAST;
  assign half    = sel_q ? HI_HALF : LO_HALF;
  assign cnt_inc = cnt_q + 1'b1;

  // Ratio is (re)loaded only at phase zero, so no period is ever cut short.
  always_comb begin
    cnt_d = cnt_inc;
    sel_d = sel_q;
    hi_d  = (cnt_inc >= half);
    if (clr_i || cnt_q == last) begin
      cnt_d = '0;
      sel_d = sel_i;
      hi_d  = 1'b0;
    end else if (!run_i && cnt_q == '0) begin
      cnt_d = '0;
      sel_d = sel_i;
      hi_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  // One true and one complement flop per pair: each drives its own load.
  for (genvar g = 0; g < int'(PAIRS); g++) begin : g_pair
    logic q_r, qn_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_r  <= 1'b0;
        qn_r <= 1'b1;
      end else begin
        q_r  <= hi_d;
        qn_r <= ~hi_d;
      end
    end
    assign q_o[g]  = q_r;
    assign qn_o[g] = qn_r;
  end
endmodule

// File: rtl/dual_ratio_clkdiv.sv
`timescale 1ns/1ps
module dual_ratio_clkdiv import clkdiv_pkg::*; #(
  parameter int unsigned PAIRS       = DEF_PAIRS,
  parameter int unsigned A_LO        = 2,
  parameter int unsigned A_HI        = 4,
  parameter int unsigned B_LO        = 4,
  parameter int unsigned B_HI        = 6,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mreset_i,
  input  logic             en_ni,
  input  logic             sel_a_i,
  input  logic             sel_b_i,
  output logic [PAIRS-1:0] qa_o,
  output logic [PAIRS-1:0] qa_n_o,
  output logic [PAIRS-1:0] qb_o,
  output logic [PAIRS-1:0] qb_n_o
);
  logic run;

  clkdiv_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_ni (en_ni),
    .run_o (run)
  );

  clkdiv_bank #(.DIV_LO(A_LO), .DIV_HI(A_HI), .PAIRS(PAIRS)) u_bank_a (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .clr_i (mreset_i),
    .sel_i (sel_a_i),
    .q_o   (qa_o),
    .qn_o  (qa_n_o)
  );

  clkdiv_bank #(.DIV_LO(B_LO), .DIV_HI(B_HI), .PAIRS(PAIRS)) u_bank_b (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .clr_i (mreset_i),
    .sel_i (sel_b_i),
    .q_o   (qb_o),
    .qn_o  (qb_n_o)
  );
endmodule

// File: rtl/clkdiv_chk.sv
`timescale 1ns/1ps
module clkdiv_chk #(
  parameter int unsigned PAIRS      = 2,
  parameter int unsigned PARK_LIMIT = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mreset_i,
  input logic             en_ni,
  input logic [PAIRS-1:0] qa_o,
  input logic [PAIRS-1:0] qa_n_o,
  input logic [PAIRS-1:0] qb_o,
  input logic [PAIRS-1:0] qb_n_o
);
  logic [7:0] off_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               off_cnt <= '0;
    else if (!en_ni)           off_cnt <= '0;
    else if (off_cnt != 8'hFF) off_cnt <= off_cnt + 8'd1;
  end

  assert_mreset_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |=> (qa_o == '0 && qb_o == '0 && qa_n_o == '1 && qb_n_o == '1));

  assert_park_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_cnt >= 8'(PARK_LIMIT)) |-> (qa_o == '0 && qb_o == '0));

  assert_complement_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qa_n_o == ~qa_o) && (qb_n_o == ~qb_o));

  assert_pair_copy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qa_o == {PAIRS{qa_o[0]}}) && (qb_o == {PAIRS{qb_o[0]}}));

  assert_b_high_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(qb_o[0]) && !mreset_i) |=> qb_o[0]);

  assert_b_low_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(qb_o[0]) |=> !qb_o[0]);
endmodule

bind dual_ratio_clkdiv clkdiv_chk #(
  .PAIRS     (PAIRS),
  .PARK_LIMIT(SYNC_STAGES + A_HI + B_HI)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mreset_i(mreset_i),
  .en_ni   (en_ni),
  .qa_o    (qa_o),
  .qa_n_o  (qa_n_o),
  .qb_o    (qb_o),
  .qb_n_o  (qb_n_o)
);

// File: tb/sim_dual_ratio_clkdiv.sv
`timescale 1ns/1ps
module sim_dual_ratio_clkdiv;
  logic clk = 1'b0, rst_n = 1'b0, mrst = 1'b0, en_n = 1'b1, sel_a = 1'b0, sel_b = 1'b0;
  logic [1:0] qa, qan, qb, qbn;
  int checks = 0, errors = 0;
  bit mon_on = 1'b0;

  always #5 clk = ~clk;

  dual_ratio_clkdiv u0 (
    .clk_i(clk), .rst_ni(rst_n), .mreset_i(mrst), .en_ni(en_n),
    .sel_a_i(sel_a), .sel_b_i(sel_b),
    .qa_o(qa), .qa_n_o(qan), .qb_o(qb), .qb_n_o(qbn)
  );

  function automatic int per_a(input bit s); return s ? 4 : 2; endfunction
  function automatic int per_b(input bit s); return s ? 6 : 4; endfunction
  function automatic bit hi_phase(input int p, input int n); return p >= n / 2; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Phase model: position inside the current period, ratio latched at period start.
  bit m_s1, m_s2, sa, sb;
  int pa, pb;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; pa <= 0; pb <= 0; sa <= 0; sb <= 0;
    end else begin
      m_s1 <= ~en_n;
      m_s2 <= m_s1;
      if (mrst || pa == per_a(sa) - 1) begin pa <= 0; sa <= sel_a; end
      else if (!m_s2 && pa == 0) sa <= sel_a;
      else pa <= pa + 1;
      if (mrst || pb == per_b(sb) - 1) begin pb <= 0; sb <= sel_b; end
      else if (!m_s2 && pb == 0) sb <= sel_b;
      else pb <= pb + 1;
    end
  end

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      chk(qa == {2{hi_phase(pa, per_a(sa))}}, "R1 bank A vs phase model", qa, {2{hi_phase(pa, per_a(sa))}});
      chk(qb == {2{hi_phase(pb, per_b(sb))}}, "R2 bank B vs phase model", qb, {2{hi_phase(pb, per_b(sb))}});
      chk(qan == ~qa && qbn == ~qb, "R9 complement", {qan, qbn}, {~qa, ~qb});
      chk(qa[0] == qa[1] && qb[0] == qb[1], "R10 pair copy", {qa, qb}, {{2{qa[0]}}, {2{qb[0]}}});
    end
  end

  function automatic bit cur(input bit use_b); return use_b ? qb[0] : qa[0]; endfunction

  task automatic wait_rise(input bit use_b);
    bit prev, now, done;
    prev = cur(use_b);
    do begin
      @(negedge clk);
      now = cur(use_b);
      done = now && !prev;
      prev = now;
    end while (!done);
  endtask

  task automatic measure(input bit use_b, output int hi_w, output int lo_w);
    wait_rise(use_b);
    hi_w = 1;
    @(negedge clk);
    while (cur(use_b)) begin hi_w++; @(negedge clk); end
    lo_w = 1;
    @(negedge clk);
    while (!cur(use_b)) begin lo_w++; @(negedge clk); end
  endtask

  task automatic count_rises(input int n, output int ra, output int rb);
    bit pva, pvb;
    ra = 0; rb = 0;
    pva = qa[0]; pvb = qb[0];
    repeat (n) begin
      @(negedge clk);
      if (qa[0] && !pva) ra++;
      if (qb[0] && !pvb) rb++;
      pva = qa[0]; pvb = qb[0];
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ra, rb, hw, lw, h, l, n, fa;
    void'($urandom(32'h0C1D_5EED));
    repeat (3) @(negedge clk);
    chk(qa == 0 && qb == 0 && qan == 3 && qbn == 3, "R11 reset state", {qa, qb, qan, qbn}, 8'b0000_1111);
    rst_n = 1'b1; mon_on = 1'b1;
    repeat (4) @(negedge clk);
    chk(qa == 0 && qb == 0, "R11 parked until enabled", {qa, qb}, 0);

    // R4: synchronizer latency
    en_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(qa == 0, "R4 bank A still low after two edges", qa, 0);
    @(negedge clk);
    chk(qa == 3, "R4 bank A high after third edge", qa, 3);
    chk(qb == 0, "R4 bank B low after third edge", qb, 0);
    @(negedge clk);
    chk(qb == 3, "R4 bank B high after fourth edge", qb, 3);

    // R1/R2: ratios by rising-edge count over 48 cycles
    for (int k = 0; k < 4; k++) begin
      sel_a = k[0]; sel_b = k[1];
      repeat (16) @(negedge clk);
      count_rises(48, ra, rb);
      chk(ra == 48 / per_a(sel_a), "R1 bank A ratio", ra, 48 / per_a(sel_a));
      chk(rb == 48 / per_b(sel_b), "R2 bank B ratio", rb, 48 / per_b(sel_b));
    end

    // R7: duty for every ratio
    for (int k = 0; k < 2; k++) begin
      sel_a = k[0]; sel_b = k[0];
      repeat (12) @(negedge clk);
      measure(1'b0, hw, lw);
      chk(hw == per_a(sel_a) / 2 && lw == hw, "R7 bank A duty", hw * 10 + lw, (per_a(sel_a) / 2) * 11);
      measure(1'b1, hw, lw);
      chk(hw == per_b(sel_b) / 2 && lw == hw, "R7 bank B duty", hw * 10 + lw, (per_b(sel_b) / 2) * 11);
    end

    // R8: select change during a high phase of bank B (/4 -> /6)
    sel_b = 1'b0;
    repeat (12) @(negedge clk);
    wait_rise(1'b1);
    sel_b = 1'b1;
    h = 1; @(negedge clk);
    while (qb[0]) begin h++; @(negedge clk); end
    chk(h == 2, "R8 current pulse keeps old width", h, 2);
    l = 1; @(negedge clk);
    while (!qb[0]) begin l++; @(negedge clk); end
    chk(l == 3, "R8 next low phase uses new ratio", l, 3);
    h = 1; @(negedge clk);
    while (qb[0]) begin h++; @(negedge clk); end
    chk(h == 3, "R8 next high phase uses new ratio", h, 3);

    // R3: master reset
    sel_a = 1'b0; sel_b = 1'b0;
    repeat (10) @(negedge clk);
    mrst = 1'b1;
    @(negedge clk);
    chk(qa == 0 && qb == 0 && qan == 3 && qbn == 3, "R3 outputs cleared", {qa, qb, qan, qbn}, 8'b0000_1111);
    repeat (2) @(negedge clk);
    chk(qa == 0 && qb == 0, "R3 held while asserted", {qa, qb}, 0);
    mrst = 1'b0;
    @(negedge clk);
    chk(qa == 3 && qb == 0, "R3 restart from low phase", {qa, qb}, 4'b1100);

    // R5/R6: park, then aligned restart
    sel_b = 1'b1;
    repeat (5) @(negedge clk);
    en_n = 1'b1;
    repeat (12) @(negedge clk);
    h = 0;
    repeat (10) begin if (qa != 0 || qb != 0) h++; @(negedge clk); end
    chk(h == 0, "R5 parked low while disabled", h, 0);
    en_n = 1'b0; n = 0; fa = 0;
    do begin
      @(negedge clk); n++;
      if (qa[0] && fa == 0) fa = n;
    end while (!qb[0]);
    chk(fa == 3, "R6 bank A first high sample", fa, 3);
    chk(n == 5, "R6 bank B first high sample", n, 5);
    h = 1; @(negedge clk);
    while (qb[0]) begin h++; @(negedge clk); end
    chk(h == 3, "R6 first pulse full width", h, 3);

    // Random traffic against the phase model (R1, R2, R9, R10)
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if ($urandom % 100 < 3) en_n = ~en_n;
      if ($urandom % 100 < 4) sel_a = ~sel_a;
      if ($urandom % 100 < 4) sel_b = ~sel_b;
      mrst = ($urandom % 100 < 2);
    end
    mrst = 1'b0; en_n = 1'b0;
    repeat (10) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule